// File: doc/BRIEF.md
# Key-Protected Power Mode Sequencer

This block decides which power state a small system sits in and drives the enables that follow from it. Software selects a target low-power mode by writing a mode register. That register is guarded by a two-word key, so a stray store cannot change it. The selected mode does not take effect at write time. It takes effect when the processor core raises its sleep request.

Three states exist. In active, everything runs. In flexi, only the core clock stops, while peripherals, memory clocks and transfer engines keep running. In hibernate, the core and the peripherals lose power and only the selected memory banks are retained. Any wake event brings the system back to active.

A regulated-supply-low input always raises a reset request. A second supply comparator can be armed for hibernate through a bit in the mode register. Reading the mode register while it holds the hibernate code aborts the pending hibernate entry.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state is active (pwrState = 0), coreClkEn = 1, periphPwrEn = 1, every retainBankEn bit is 1, resetReq = 0, and a read of the mode register returns 0.
- R2: Registers are selected by regAddr: 0 is the key register and 1 is the mode register. A mode-register write is accepted only if the two previous bus writes were key writes of 0x4859 and then 0xF27B. Any other key value returns the unlock to idle, except that 0x4859 always restarts it at the first step. Any mode-register write also returns the unlock to idle. A write that is not accepted leaves the readback unchanged.
- R3: One unlock allows exactly one mode-register write. A second write without a fresh key pair is ignored.
- R4: Mode register layout: bits [1:0] hold the target mode (0 active, 1 flexi, 2 hibernate), bit 3 disables the auxiliary monitor, and bits [5:4] hold the retention select. All other read bits are 0. With target mode 1, a sleep request moves pwrState to 1 on the next clock. In that state coreClkEn = 0, periphPwrEn = 1 and all retention banks stay enabled.
- R5: With target mode 2, a sleep request moves pwrState to 2 on the next clock. In that state coreClkEn = 0 and periphPwrEn = 0. retainBankEn has its lowest (retention select + 1) bits set, with one 8 kB bank per bit (00 gives 8 kB, 11 gives 32 kB).
- R6: A wake event in flexi or hibernate returns pwrState to 0 on the next clock. The mode register keeps its contents.
- R7: A sleep request while the target mode is 0 or 3 leaves the block in active.
- R8: A read of the mode register in active while the target mode is 2 returns the stored value. It also clears the target mode to 0, so a later sleep request does not enter hibernate.
- R9: supplyLow high at a clock edge makes resetReq high after that edge, in any state.
- R10: auxSupplyLow raises resetReq only in hibernate with mode bit 3 = 0. In other states, or with bit 3 = 1, it has no effect on resetReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 selects the key register, 1 selects the mode register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Mode register readback while a read of address 1 is active, otherwise 0 |
| sleepReq | input | 1 | Core sleep request |
| wakeEvt | input | 1 | Wake event |
| supplyLow | input | 1 | Regulated supply below its retention limit |
| auxSupplyLow | input | 1 | Auxiliary supply comparator output |
| coreClkEn | output | 1 | Core clock enable |
| periphPwrEn | output | 1 | Peripheral power enable |
| retainBankEn | output | 4 | Per-bank memory retention enables |
| resetReq | output | 1 | Chip reset request |
| pwrState | output | 2 | Current state: 0 active, 1 flexi, 2 hibernate |

## Verification
A key stage that is left open when it should be closed shows up as a mode readback that changes after a write that should have been ignored. That difference appears on the very next read. A wrong power state is visible on pwrState and on the enables one clock after the sleep or wake edge. A retention select that was stored wrongly shows as a wrong bank mask as soon as hibernate is entered. A missed hibernate cancel shows as an entry into state 2 on the next sleep request. The sweep covers every target mode, retention select and monitor setting, so each of these faults reaches the ports within a few cycles of the stimulus that exposes it.

// File: rtl/pwr_mode_seq_pkg.sv
package pwr_mode_seq_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_FLEXI  = 2'd1,
    PS_HIBER  = 2'd2
  } pwrState_t;

  localparam logic [1:0] MODE_ACTIVE = 2'd0;
  localparam logic [1:0] MODE_FLEXI  = 2'd1;
  localparam logic [1:0] MODE_HIBER  = 2'd2;

  localparam logic ADDR_KEY  = 1'b0;
  localparam logic ADDR_MODE = 1'b1;

  localparam int MODE_LSB   = 0;
  localparam int AUXOFF_BIT = 3;
  localparam int RET_LSB    = 4;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_HALF = 2'd1,
    K_OPEN = 2'd2
  } keyStage_t;

  typedef struct packed {
    logic modeWr;
    logic modeCancel;
  } ctrlStb_t;

endpackage

// File: rtl/pwr_mode_seq_ctrl.sv
module pwr_mode_seq_ctrl
  import pwr_mode_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'(16'h4859),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'(16'hF27B)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              sleepReq,
  input  logic              wakeEvt,
  input  logic              supplyLow,
  input  logic              auxSupplyLow,
  input  logic [1:0]        progMode,
  input  logic              auxMonOff,
  output ctrlStb_t          ctrlStb,
  output pwrState_t         stateQ,
  output logic              resetReq
);

  keyStage_t keyStage, keyStageNext;
  pwrState_t stateNext;
  logic      keyWrite, modeWrite, modeRead;

  assign keyWrite  = regWrEn && (regAddr == ADDR_KEY);
  assign modeWrite = regWrEn && (regAddr == ADDR_MODE);
  assign modeRead  = regRdEn && !regWrEn && (regAddr == ADDR_MODE);

  // Unlock sequencing
  always_comb begin
    keyStageNext = keyStage;
    if (keyWrite) begin
      if (regWrData == KEY_FIRST)
        keyStageNext = K_HALF;
      else if (keyStage == K_HALF && regWrData == KEY_SECOND)
        keyStageNext = K_OPEN;
      else
        keyStageNext = K_IDLE;
    end else if (modeWrite) begin
      keyStageNext = K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyStage <= K_IDLE;
    else       keyStage <= keyStageNext;
  end

  assign ctrlStb.modeWr     = modeWrite && (keyStage == K_OPEN);
  assign ctrlStb.modeCancel = modeRead && (progMode == MODE_HIBER) &&
                              (stateQ == PS_ACTIVE);

  // Power state sequencing
  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      PS_ACTIVE: begin
        if (sleepReq && !ctrlStb.modeCancel) begin
          if (progMode == MODE_FLEXI)      stateNext = PS_FLEXI;
          else if (progMode == MODE_HIBER) stateNext = PS_HIBER;
        end
      end
      PS_FLEXI, PS_HIBER: begin
        if (wakeEvt) stateNext = PS_ACTIVE;
      end
      default: stateNext = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PS_ACTIVE;
    else       stateQ <= stateNext;
  end

  // Supply supervision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= supplyLow ||
                           ((stateQ == PS_HIBER) && !auxMonOff && auxSupplyLow);
  end

endmodule

// File: rtl/pwr_mode_seq_dp.sv
module pwr_mode_seq_dp
  import pwr_mode_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 4,
  parameter int RET_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regRdEn,
  input  logic                 regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  ctrlStb_t             ctrlStb,
  input  pwrState_t            stateQ,
  output logic [1:0]           progMode,
  output logic                 auxMonOff,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 coreClkEn,
  output logic                 periphPwrEn,
  output logic [NUM_BANKS-1:0] retainBankEn
);

  logic [RET_W-1:0]  retSel;
  logic [DATA_W-1:0] modeImage;
  logic              unusedWrBits;

  assign unusedWrBits = ^{regWrData[DATA_W-1:RET_LSB+RET_W], regWrData[2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progMode  <= MODE_ACTIVE;
      auxMonOff <= 1'b0;
      retSel    <= '0;
    end else if (ctrlStb.modeWr) begin
      progMode  <= regWrData[MODE_LSB +: 2];
      auxMonOff <= regWrData[AUXOFF_BIT];
      retSel    <= regWrData[RET_LSB +: RET_W];
    end else if (ctrlStb.modeCancel) begin
      progMode  <= MODE_ACTIVE;
    end
  end

  always_comb begin
    modeImage                      = '0;
    modeImage[MODE_LSB +: 2]       = progMode;
    modeImage[AUXOFF_BIT]          = auxMonOff;
    modeImage[RET_LSB +: RET_W]    = retSel;
  end

  assign regRdData = (regRdEn && regAddr == ADDR_MODE) ? modeImage : '0;

  assign coreClkEn   = (stateQ == PS_ACTIVE);
  assign periphPwrEn = (stateQ != PS_HIBER);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign retainBankEn[b] = (stateQ != PS_HIBER) || (b <= int'(retSel));
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 4,
  parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'(16'h4859),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'(16'hF27B)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic                 regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 sleepReq,
  input  logic                 wakeEvt,
  input  logic                 supplyLow,
  input  logic                 auxSupplyLow,
  output logic                 coreClkEn,
  output logic                 periphPwrEn,
  output logic [NUM_BANKS-1:0] retainBankEn,
  output logic                 resetReq,
  output logic [1:0]           pwrState
);

  localparam int RET_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  ctrlStb_t   ctrlStb;
  pwrState_t  stateQ;
  logic [1:0] progMode;
  logic       auxMonOff;

  pwr_mode_seq_ctrl #(
    .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .sleepReq(sleepReq),
    .wakeEvt(wakeEvt), .supplyLow(supplyLow), .auxSupplyLow(auxSupplyLow),
    .progMode(progMode), .auxMonOff(auxMonOff), .ctrlStb(ctrlStb),
    .stateQ(stateQ), .resetReq(resetReq)
  );

  pwr_mode_seq_dp #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .RET_W(RET_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctrlStb(ctrlStb), .stateQ(stateQ),
    .progMode(progMode), .auxMonOff(auxMonOff), .regRdData(regRdData),
    .coreClkEn(coreClkEn), .periphPwrEn(periphPwrEn),
    .retainBankEn(retainBankEn)
  );

  assign pwrState = stateQ;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
  import pwr_mode_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 4,
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'(16'hF27B)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic                 regRdEn,
  input logic                 regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic                 wakeEvt,
  input logic                 supplyLow,
  input logic                 coreClkEn,
  input logic                 periphPwrEn,
  input logic [NUM_BANKS-1:0] retainBankEn,
  input logic                 resetReq,
  input logic [1:0]           pwrState,
  input logic [1:0]           progMode,
  input ctrlStb_t             ctrlStb
);

  AST_ACTIVE_ALL_ON: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd0 |-> coreClkEn && periphPwrEn && (&retainBankEn)); // R1

  AST_MODE_WR_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.modeWr |-> $past(regWrEn && regAddr == ADDR_KEY && regWrData == KEY_SECOND)); // R2

  AST_FLEXI_CORE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd1 |-> !coreClkEn && periphPwrEn && (&retainBankEn)); // R4

  AST_HIBER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd2 |-> !coreClkEn && !periphPwrEn && retainBankEn[0]); // R5

  AST_WAKE_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'd0 && wakeEvt) |=> pwrState == 2'd0); // R6

  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == ADDR_MODE && progMode == MODE_HIBER && pwrState == 2'd0)
      |=> progMode == MODE_ACTIVE); // R8

  AST_SUPPLY_RESET: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> resetReq); // R9

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3); // R6

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
  .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .KEY_SECOND(KEY_SECOND)
) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .wakeEvt(wakeEvt),
  .supplyLow(supplyLow), .coreClkEn(coreClkEn), .periphPwrEn(periphPwrEn),
  .retainBankEn(retainBankEn), .resetReq(resetReq), .pwrState(pwrState),
  .progMode(progMode), .ctrlStb(ctrlStb)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regRdEn, regAddr;
  logic [15:0] regWrData, regRdData;
  logic        sleepReq, wakeEvt, supplyLow, auxSupplyLow;
  logic        coreClkEn, periphPwrEn, resetReq;
  logic [3:0]  retainBankEn;
  logic [1:0]  pwrState;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_seq dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sleepReq(sleepReq), .wakeEvt(wakeEvt), .supplyLow(supplyLow),
    .auxSupplyLow(auxSupplyLow), .coreClkEn(coreClkEn),
    .periphPwrEn(periphPwrEn), .retainBankEn(retainBankEn),
    .resetReq(resetReq), .pwrState(pwrState)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic keyWr(input logic [15:0] d);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic modeWr(input logic [15:0] d);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic modeRd(output logic [15:0] d);
    regRdEn = 1'b1; regAddr = 1'b1;
    #1 d = regRdData;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic unlock();
    keyWr(16'h4859);
    keyWr(16'hF27B);
  endtask

  task automatic pulseSleep();
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    wakeEvt = 1'b1; tick(); wakeEvt = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    sleepReq = 0; wakeEvt = 0; supplyLow = 0; auxSupplyLow = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 state", pwrState, 0);
    chk("R1 core", coreClkEn, 1);
    chk("R1 periph", periphPwrEn, 1);
    chk("R1 banks", retainBankEn, 4'hF);
    chk("R1 reset", resetReq, 0);
    modeRd(rd); chk("R1 readback", rd, 0);

    // R2 write without key
    modeWr(16'h0001); modeRd(rd); chk("R2 no key", rd, 0);
    // R2 wrong second word
    keyWr(16'h4859); keyWr(16'h1234); modeWr(16'h0001);
    modeRd(rd); chk("R2 bad second", rd, 0);
    // R2 words swapped
    keyWr(16'hF27B); keyWr(16'h4859); modeWr(16'h0001);
    modeRd(rd); chk("R2 swapped", rd, 0);
    // R2 mode write between key words
    keyWr(16'h4859); modeWr(16'h0011); keyWr(16'hF27B); modeWr(16'h0001);
    modeRd(rd); chk("R2 interleaved", rd, 0);
    // R2 repeated first word restarts the sequence
    keyWr(16'h4859); keyWr(16'h4859); keyWr(16'hF27B); modeWr(16'h0031);
    modeRd(rd); chk("R2 restart accepted", rd, 16'h0031);
    // R3 unlock consumed
    modeWr(16'h0000); modeRd(rd); chk("R3 consumed", rd, 16'h0031);

    // Sweep: every target mode, retention select, monitor setting
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        for (int a = 0; a < 2; a++) begin
          logic [15:0] val;
          int expSt;
          val = 16'((r << 4) | (a << 3) | m);
          expSt = (m == 1) ? 1 : (m == 2) ? 2 : 0;
          unlock(); modeWr(val);
          pulseSleep();
          if (expSt == 0) chk("R7 stay active", pwrState, 0);
          else if (expSt == 1) chk("R4 flexi state", pwrState, 1);
          else chk("R5 hibernate state", pwrState, 2);
          chk(expSt == 1 ? "R4 core" : expSt == 2 ? "R5 core" : "R7 core",
              coreClkEn, (expSt == 0));
          chk(expSt == 2 ? "R5 periph" : "R4 periph", periphPwrEn, (expSt != 2));
          chk(expSt == 2 ? "R5 banks" : "R4 banks", retainBankEn,
              (expSt == 2) ? 4'((1 << (r + 1)) - 1) : 4'hF);
          // R10 auxiliary monitor
          auxSupplyLow = 1'b1; tick(); auxSupplyLow = 1'b0;
          chk("R10 aux reset", resetReq, (expSt == 2 && a == 0));
          tick();
          chk("R10 aux release", resetReq, 0);
          if (expSt != 0) begin
            pulseWake();
            chk("R6 wake state", pwrState, 0);
            chk("R6 wake core", coreClkEn, 1);
          end
          modeRd(rd); chk("R6 mode kept", rd, val);
        end
      end
    end

    // R8 readback cancels hibernate entry
    unlock(); modeWr(16'h0012);
    modeRd(rd); chk("R8 first read", rd, 16'h0012);
    modeRd(rd); chk("R8 mode cleared", rd, 16'h0010);
    pulseSleep(); chk("R8 no entry", pwrState, 0);

    // R9 supply low in active and in flexi
    supplyLow = 1'b1; tick(); supplyLow = 1'b0;
    chk("R9 active reset", resetReq, 1);
    tick(); chk("R9 release", resetReq, 0);
    unlock(); modeWr(16'h0001); pulseSleep();
    chk("R4 flexi again", pwrState, 1);
    supplyLow = 1'b1; tick(); supplyLow = 1'b0;
    chk("R9 flexi reset", resetReq, 1);
    chk("R9 flexi state", pwrState, 1);
    pulseWake(); chk("R6 final wake", pwrState, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule